// File: doc/BRIEF.md
# Clock Synthesizer Serial Programmer

This block programs an external frequency synthesizer over a three-wire serial link. A host presents a feedback divider, a reference divider, a VCO band choice and an output divider, then pulses a load strobe. The block checks every value against the range the synthesizer accepts. A bad set of values is refused: the block raises an error flag and sends nothing. A good set of values is packed into one fixed 27-bit programming word and sent with its least significant bit first. Each bit comes with its own serial clock pulse.

While the word is being sent, the synthesizer's output-enable line is held low. This keeps a half-programmed clock from reaching the logic downstream. Once the last bit has gone out, the enable line returns high and a one-cycle done pulse tells the host that the new setting is in place. The serial clock runs at a fixed fraction of the system clock, set by the half-period parameter.

Top module: `synth_prog`

## Requirements
- R1: After reset the enable output is high, and the serial clock, serial data, done and error outputs are all low.
- R2: A load strobe is taken only while the block is idle. The values are legal when both dividers are at least 3 (the 7-bit inputs cap them at 127), the VCO select is 1 or 8, and the output divider is 1, 2, 4 or 8.
- R3: An illegal load sets the error output from the next cycle on and holds it until the next accepted load. It causes no serial clock, no drop of the enable line and no done pulse.
- R4: A legal load clears the error output and sends exactly 27 bits, with one rising serial clock edge per bit.
- R5: The bits go out in this order: feedback divider bits 0 to 6, reference divider bits 0 to 6, a VCO bit (1 for select 8, 0 for select 1), two 1s, an output-divider bit (1 for 2 or 8), a second output-divider bit (1 for 4 or 8), a 1 that turns the clock output on, a 0 that turns the divided output off, then 1,0,1,0,0,0.
- R6: The enable line falls in the cycle after an accepted load. It then stays low for HALF_PER idle cycles before the first bit. Each bit is shown for HALF_PER cycles with the serial clock low, then for HALF_PER cycles with the serial clock high and the data unchanged.
- R7: After the last bit come HALF_PER cycles with clock and data low and the enable line still low. Then, in one cycle, the enable line rises and done pulses high. The block is idle in the cycle after that.
- R8: A load strobe that arrives while a word is being sent, or during the done cycle, is ignored: it changes neither the word nor the error output.
- R9: The serial clock is never high while the enable line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Request to program the synthesizer with the current values |
| fb_div_i | input | 7 | Feedback divider, legal 3..127 |
| ref_div_i | input | 7 | Reference divider, legal 3..127 |
| vco_sel_i | input | 4 | VCO band select, legal 1 or 8 |
| out_div_i | input | 4 | Output divider, legal 1, 2, 4 or 8 |
| sdata_o | output | 1 | Serial programming data |
| sclk_o | output | 1 | Serial programming clock |
| oe_o | output | 1 | Synthesizer output enable, low while a word is loaded |
| err_o | output | 1 | Last accepted load had illegal values |
| done_o | output | 1 | One-cycle pulse when programming completes |

## Verification
The bench builds the block with HALF_PER set to 3 and keeps the default 7-bit divider width. With three cycles per half period, the setup gap, the low and high phases of each bit, and the trailing gap are all wider than one cycle, so an off-by-one in the phase timer shows up in a per-cycle comparison. The frame stays at 27 bits, short enough for runs that cover the divider extremes 3 and 127 and every legal output divider. It also leaves room for loads timed into a running frame and into the done cycle.

// File: rtl/synth_prog_pkg.sv
// Package: shared types and constants for the synthesizer programmer.
// Assumes the control part of the frame is a fixed 13 bits after the dividers.
package synth_prog_pkg;

    // Sequencer phases of one programming cycle
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_SETUP = 3'd1,
        SEQ_LOW   = 3'd2,
        SEQ_HIGH  = 3'd3,
        SEQ_TRAIL = 3'd4,
        SEQ_DONE  = 3'd5
    } seq_state_e;

    // Bits in the frame after the two dividers
    localparam int CTRL_BITS = 13;

    // Total frame length for a given divider width
    function automatic int frame_len(input int div_w);
        return 2 * div_w + CTRL_BITS;
    endfunction

endpackage

// File: rtl/synth_frame_build.sv
// Module: checks the parameter set and assembles the programming frame.
// Pure combinational logic. Frame bit 0 goes out first. Assumes SEL_W >= 4.
module synth_frame_build
    import synth_prog_pkg::*;
#(
    parameter int DIV_W   = 7,
    parameter int SEL_W   = 4,
    parameter int DIV_MIN = 3,
    localparam int FRAME_LEN = frame_len(DIV_W)
) (
    input  logic [DIV_W-1:0]     fb_div,
    input  logic [DIV_W-1:0]     ref_div,
    input  logic [SEL_W-1:0]     vco_sel,
    input  logic [SEL_W-1:0]     out_div,
    output logic                 legal,
    output logic [FRAME_LEN-1:0] frame
);

    localparam logic [DIV_W-1:0] LOW_LIMIT = DIV_W'(DIV_MIN);
    localparam logic [SEL_W-1:0] SEL_ONE   = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_TWO   = SEL_W'(2);
    localparam logic [SEL_W-1:0] SEL_FOUR  = SEL_W'(4);
    localparam logic [SEL_W-1:0] SEL_EIGHT = SEL_W'(8);
    localparam int CTRL_BASE = 2 * DIV_W;

    logic div_ok;
    logic vco_ok;
    logic odiv_ok;
    logic vco_bit;
    logic odiv_b0;
    logic odiv_b1;
    logic [CTRL_BITS-1:0] ctrl;

    // Range checks on every field
    always_comb begin
        div_ok  = (fb_div >= LOW_LIMIT) && (ref_div >= LOW_LIMIT);
        vco_ok  = (vco_sel == SEL_ONE) || (vco_sel == SEL_EIGHT);
        odiv_ok = (out_div == SEL_ONE) || (out_div == SEL_TWO) ||
                  (out_div == SEL_FOUR) || (out_div == SEL_EIGHT);
        legal   = div_ok && vco_ok && odiv_ok;
    end

    // Encoded control bits
    always_comb begin
        vco_bit = (vco_sel == SEL_EIGHT);
        odiv_b0 = (out_div == SEL_TWO) || (out_div == SEL_EIGHT);
        odiv_b1 = (out_div == SEL_FOUR) || (out_div == SEL_EIGHT);
        // index 0 is sent first: vco, 1, 1, r0, r1, clk on, div off, 1,0,1,0,0,0
        ctrl = {6'b000101, 1'b0, 1'b1, odiv_b1, odiv_b0, 1'b1, 1'b1, vco_bit};
    end

    // Place the divider bits, LSB first, feedback before reference
    for (genvar gi = 0; gi < DIV_W; gi++) begin : g_div_bits
        assign frame[gi]         = fb_div[gi];
        assign frame[DIV_W + gi] = ref_div[gi];
    end

    // Place the control bits after the dividers
    for (genvar gc = 0; gc < CTRL_BITS; gc++) begin : g_ctrl_bits
        assign frame[CTRL_BASE + gc] = ctrl[gc];
    end

endmodule

// File: rtl/synth_phase_timer.sv
// Module: counts HALF_PER cycles per serial half period while enabled.
// Clears to zero whenever it is not running. Synchronous active-low reset.
module synth_phase_timer #(
    parameter int HALF_PER = 2,
    localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);

    logic [CW-1:0] cnt;

    // Phase end marker
    assign tick = run && (cnt == LAST);

    // Free-running counter inside a phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/synth_seq_ctrl.sv
// Module: sequencer for setup, per-bit low/high phases, trailing gap and done.
// Assumes the legal flag is valid in the cycle the load strobe is high.
module synth_seq_ctrl
    import synth_prog_pkg::*;
#(
    parameter int FRAME_LEN = 27,
    localparam int BW = $clog2(FRAME_LEN)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       legal,
    input  logic       tick,
    output seq_state_e state,
    output logic       run,
    output logic       capture,
    output logic       shift,
    output logic       err
);

    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_LEN - 1);

    seq_state_e    nxt;
    logic [BW-1:0] bit_idx;
    logic          last_bit;

    // Timer runs in every timed phase
    assign run      = (state == SEQ_SETUP) || (state == SEQ_LOW) ||
                      (state == SEQ_HIGH)  || (state == SEQ_TRAIL);
    assign capture  = (state == SEQ_IDLE) && load && legal;
    assign last_bit = (bit_idx == LAST_BIT);
    assign shift    = (state == SEQ_HIGH) && tick && !last_bit;

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE:  if (capture) nxt = SEQ_SETUP;
            SEQ_SETUP: if (tick)    nxt = SEQ_LOW;
            SEQ_LOW:   if (tick)    nxt = SEQ_HIGH;
            SEQ_HIGH:  if (tick)    nxt = last_bit ? SEQ_TRAIL : SEQ_LOW;
            SEQ_TRAIL: if (tick)    nxt = SEQ_DONE;
            SEQ_DONE:               nxt = SEQ_IDLE;
            default:                nxt = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= nxt;
    end

    // Bit position within the frame
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_idx <= '0;
        else if (capture) bit_idx <= '0;
        else if (shift)   bit_idx <= bit_idx + BW'(1);
    end

    // Error flag, updated only by a load taken while idle
    always_ff @(posedge clk) begin
        if (!rst_n)                        err <= 1'b0;
        else if (state == SEQ_IDLE && load) err <= !legal;
    end

endmodule

// File: rtl/synth_frame_shift.sv
// Module: holds the captured frame and presents one bit at a time.
// Bit 0 is presented first; a shift moves the next bit into place.
module synth_frame_shift #(
    parameter int FRAME_LEN = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic                 shift,
    input  logic [FRAME_LEN-1:0] frame_in,
    output logic                 cur_bit
);

    logic [FRAME_LEN-1:0] sh;

    assign cur_bit = sh[0];

    // Load or shift toward bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)       sh <= '0;
        else if (capture) sh <= frame_in;
        else if (shift)   sh <= {1'b0, sh[FRAME_LEN-1:1]};
    end

endmodule

// File: rtl/synth_prog.sv
// Module: top of the synthesizer serial programmer.
// Checks the values, then sends the frame with the enable line dropped.
// Outputs are decoded from registered state only. Sync active-low reset.
module synth_prog
    import synth_prog_pkg::*;
#(
    parameter int DIV_W    = 7,
    parameter int SEL_W    = 4,
    parameter int DIV_MIN  = 3,
    parameter int HALF_PER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] fb_div_i,
    input  logic [DIV_W-1:0] ref_div_i,
    input  logic [SEL_W-1:0] vco_sel_i,
    input  logic [SEL_W-1:0] out_div_i,
    output logic             sdata_o,
    output logic             sclk_o,
    output logic             oe_o,
    output logic             err_o,
    output logic             done_o
);

    localparam int FRAME_LEN = frame_len(DIV_W);

    logic                 legal;
    logic [FRAME_LEN-1:0] frame;
    logic                 tick;
    logic                 run;
    logic                 capture;
    logic                 shift;
    logic                 cur_bit;
    seq_state_e           state;

    synth_frame_build #(
        .DIV_W  (DIV_W),
        .SEL_W  (SEL_W),
        .DIV_MIN(DIV_MIN)
    ) u_build (
        .fb_div (fb_div_i),
        .ref_div(ref_div_i),
        .vco_sel(vco_sel_i),
        .out_div(out_div_i),
        .legal  (legal),
        .frame  (frame)
    );

    synth_phase_timer #(
        .HALF_PER(HALF_PER)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    synth_seq_ctrl #(
        .FRAME_LEN(FRAME_LEN)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_i),
        .legal  (legal),
        .tick   (tick),
        .state  (state),
        .run    (run),
        .capture(capture),
        .shift  (shift),
        .err    (err_o)
    );

    synth_frame_shift #(
        .FRAME_LEN(FRAME_LEN)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .shift   (shift),
        .frame_in(frame),
        .cur_bit (cur_bit)
    );

    // Output decode from the sequencer phase
    always_comb begin
        oe_o    = (state == SEQ_IDLE) || (state == SEQ_DONE);
        sclk_o  = (state == SEQ_HIGH);
        sdata_o = ((state == SEQ_LOW) || (state == SEQ_HIGH)) && cur_bit;
        done_o  = (state == SEQ_DONE);
    end

endmodule

// File: rtl/synth_prog_checks.sv
// Checker: temporal properties on the programmer's ports.
// Counts rising serial clock edges per frame to check the frame length.
module synth_prog_checks
    import synth_prog_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input logic clk,
    input logic rst_n,
    input logic load_i,
    input logic sdata_o,
    input logic sclk_o,
    input logic oe_o,
    input logic err_o,
    input logic done_o
);

    localparam int FLEN = frame_len(DIV_W);

    logic        sclk_q;
    logic [7:0]  rise_cnt;

    // Count serial clock rises while the enable line is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_q <= sclk_o;
            if (oe_o)                  rise_cnt <= '0;
            else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 8'd1;
        end
    end

    p_sclk_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !oe_o);

    p_done_with_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (oe_o && !sclk_o && !sdata_o));

    p_oe_back_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> done_o);

    p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (oe_o && !sclk_o && !done_o));

    p_data_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdata_o));

    p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rise_cnt == 8'(FLEN)));

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_o || done_o) |=> $stable(err_o));

    p_setup_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_o) |-> (!sclk_o && !sdata_o));

endmodule

bind synth_prog synth_prog_checks #(.DIV_W(DIV_W)) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .sdata_o(sdata_o),
    .sclk_o (sclk_o),
    .oe_o   (oe_o),
    .err_o  (err_o),
    .done_o (done_o)
);

// File: tb/test_synth_prog.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model with expectation queues.
module test_synth_prog;

    localparam int HP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [6:0] fb_div_i = 7'd0;
    logic [6:0] ref_div_i = 7'd0;
    logic [3:0] vco_sel_i = 4'd0;
    logic [3:0] out_div_i = 4'd0;
    logic       sdata_o, sclk_o, oe_o, err_o, done_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // expected {oe, sclk, sdata, done} per cycle, with a requirement tag
    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic       exp_err = 1'b0;
    bit         running = 0;
    bit         idle_now = 1;
    bit         last_done = 0;

    always #2.5 clk = ~clk;

    synth_prog #(.HALF_PER(HP)) i_synth_prog (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .fb_div_i(fb_div_i), .ref_div_i(ref_div_i),
        .vco_sel_i(vco_sel_i), .out_div_i(out_div_i),
        .sdata_o(sdata_o), .sclk_o(sclk_o), .oe_o(oe_o),
        .err_o(err_o), .done_o(done_o)
    );

    function automatic bit is_legal(int n, int m, int v, int r);
        return (n >= 3) && (m >= 3) && (v == 1 || v == 8) &&
               (r == 1 || r == 2 || r == 4 || r == 8);
    endfunction

    // Builds the expected timeline for one legal frame (R5, R6, R7)
    function automatic void push_frame(int n, int m, int v, int r);
        bit bits[$];
        for (int i = 0; i < 7; i++) bits.push_back(((n >> i) & 1) != 0);
        for (int i = 0; i < 7; i++) bits.push_back(((m >> i) & 1) != 0);
        bits.push_back(v == 8);
        bits.push_back(1); bits.push_back(1);
        bits.push_back(r == 2 || r == 8);
        bits.push_back(r == 4 || r == 8);
        bits.push_back(1); bits.push_back(0);
        bits.push_back(1); bits.push_back(0); bits.push_back(1);
        bits.push_back(0); bits.push_back(0); bits.push_back(0);
        for (int k = 0; k < HP; k++) begin exp_q.push_back(4'b0000); tag_q.push_back("R6"); end
        foreach (bits[b]) begin
            for (int k = 0; k < HP; k++) begin exp_q.push_back({2'b00, bits[b], 1'b0}); tag_q.push_back("R5"); end
            for (int k = 0; k < HP; k++) begin exp_q.push_back({2'b01, bits[b], 1'b0}); tag_q.push_back("R6"); end
        end
        for (int k = 0; k < HP; k++) begin exp_q.push_back(4'b0000); tag_q.push_back("R7"); end
        exp_q.push_back(4'b1001); tag_q.push_back("R7");
    endfunction

    // Model: decide acceptance on the edge where the design samples load (R2, R8)
    always @(posedge clk) begin
        if (rst_n && running && load_i && idle_now) begin
            exp_err = !is_legal(fb_div_i, ref_div_i, vco_sel_i, out_div_i);
            if (!exp_err) push_frame(fb_div_i, ref_div_i, vco_sel_i, out_div_i);
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (running && !finished) begin
            logic [3:0] e;
            string t;
            idle_now = (exp_q.size() == 0);
            if (idle_now) begin e = 4'b1000; t = "R8"; end
            else begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
            last_done = (e == 4'b1001);
            total++;
            if ({oe_o, sclk_o, sdata_o, done_o} !== e) begin
                bad++;
                $display("FAIL %s oe/sclk/sdata/done actual=%b expected=%b at %0t",
                         t, {oe_o, sclk_o, sdata_o, done_o}, e, $time);
            end
            total++;
            if (err_o !== exp_err) begin
                bad++;
                $display("FAIL R3 err_o actual=%b expected=%b at %0t", err_o, exp_err, $time);
            end
        end
    end

    task automatic put(int n, int m, int v, int r, bit ld);
        fb_div_i = 7'(n); ref_div_i = 7'(m); vco_sel_i = 4'(v); out_div_i = 4'(r);
        load_i = ld;
    endtask

    task automatic do_load(int n, int m, int v, int r);
        @(negedge clk); #1;
        put(n, m, v, r, 1'b1);
        @(negedge clk); #1;
        load_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) begin @(negedge clk); #1; end
        repeat (2) begin @(negedge clk); #1; end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        total++;
        if ({oe_o, sclk_o, sdata_o, done_o, err_o} !== 5'b10000) begin
            bad++;
            $display("FAIL R1 reset outputs actual=%b expected=10000",
                     {oe_o, sclk_o, sdata_o, done_o, err_o});
        end
        running = 1;
        // R4 R5: divider extremes, smallest settings
        do_load(3, 127, 1, 1);   wait_idle();
        do_load(100, 45, 8, 8);  wait_idle();
        do_load(85, 42, 8, 2);   wait_idle();
        do_load(127, 3, 1, 4);   wait_idle();
        // R2 R3: each kind of illegal value
        do_load(2, 50, 1, 1);    wait_idle();
        do_load(50, 0, 1, 1);    wait_idle();
        do_load(50, 50, 2, 1);   wait_idle();
        do_load(50, 50, 1, 3);   wait_idle();
        do_load(50, 50, 8, 0);   wait_idle();
        // R4: legal load clears the error
        do_load(9, 17, 1, 2);    wait_idle();
        // R8: loads during a frame are ignored
        do_load(64, 33, 8, 4);
        repeat (30) begin @(negedge clk); #1; end
        put(1, 1, 3, 5, 1'b1);
        @(negedge clk); #1; load_i = 1'b0;
        repeat (40) begin @(negedge clk); #1; end
        put(70, 71, 1, 8, 1'b1);
        @(negedge clk); #1; load_i = 1'b0;
        // R8: load held across the done cycle is taken only once idle
        put(5, 6, 8, 1, 1'b0);
        last_done = 0;
        while (!last_done) begin @(negedge clk); #1; end
        load_i = 1'b1;   // design is in the done cycle now
        @(negedge clk); #1;
        @(negedge clk); #1;
        load_i = 1'b0;
        wait_idle();
        summary();
    end

endmodule